// File: doc/BRIEF.md
# Oversampled Serial Receiver with Batched Ready

This block turns an asynchronous serial line into characters. The serial line passes through a two-stage synchronizer. The receiver then times each frame with a 16x oversample strobe and samples every bit at the middle of its cell. The frame format is set by live configuration inputs: data width from one to eight bits, an optional parity bit with odd or even sense, and one or two stop bits. Every completed frame is written into an internal character queue. The same cycle carries one-cycle pulses that report parity faults, bad stop bits and line breaks.

Software is not told about each character as it arrives. The ready output is held back until a programmable number of bit times has passed since the queue last became non-empty. This lets a driver take several characters per service call. A delay of about ten frame lengths, 110 bit times for 11-bit frames, is a typical setting. A delay of zero makes ready follow the queue state with one cycle of lag. Characters are read from the queue head and removed with a one-cycle pop.

Top module: `uart_rx_dlyrdy`

## Requirements
- R1: The data width is `cfg_width_sel + 1` bits. Bits arrive least significant first. `wr_data` holds them right-aligned, and all bits above the width read zero.
- R2: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_even` = 1, the data bits and the parity bit together must have an even count of ones; with 0, an odd count. A mismatch raises `pe_pulse` with the frame. With parity disabled, no parity bit is taken and `pe_pulse` stays 0.
- R3: `cfg_two_stop` = 1 takes two stop bits, and 0 takes one. `fe_pulse` is raised with the frame when any sampled stop bit is low.
- R4: `brk_pulse` is raised together with `fe_pulse` when three conditions hold: every data bit is zero, the parity bit (if enabled) is zero, and the first stop bit is low.
- R5: A frame starts only on a high-to-low transition of the line. If the line is high again at the middle of the start bit, the transition is dropped as a glitch, and nothing is written.
- R6: Each completed frame pulses `wr_valid` for one cycle and is written to a first-in first-out queue of 16 characters. `rd_data` shows the oldest character, and `rd_count` shows the fill level. A pop when the queue is empty has no effect.
- R7: A frame that completes while the queue holds 16 characters, with no pop in that cycle, is discarded. `ovr_pulse` rises for one cycle, and `rd_count` stays at 16.
- R8: With `cfg_rdy_dly` = D > 0, `rx_ready` rises D bit times (D x 16 oversample strobes) after `rd_count` leaves zero. It stays high while the queue is non-empty and drops in the cycle the queue becomes empty.
- R9: With `cfg_rdy_dly` = 0, `rx_ready` is high from the cycle after the queue becomes non-empty.
- R10: After reset, `rd_count` is 0, and `rx_ready` and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| os_tick | input | 1 | Oversample strobe, 16 per bit time |
| cfg_width_sel | input | SEL_W (3) | Data width minus one |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_rdy_dly | input | DLY_W (8) | Ready delay in bit times |
| rd_pop | input | 1 | Remove the head character |
| wr_valid | output | 1 | Frame completed, character written |
| wr_data | output | DATA_W (8) | Character of the completed frame |
| rd_data | output | DATA_W (8) | Oldest queued character |
| rd_count | output | CNT_W (5) | Queue fill level |
| brk_pulse | output | 1 | Break seen |
| fe_pulse | output | 1 | Low stop bit seen |
| pe_pulse | output | 1 | Parity mismatch |
| ovr_pulse | output | 1 | Character lost to a full queue |
| rx_ready | output | 1 | Delayed ready indication |

## Verification
The bench uses the default build: eight-bit data, a 16-entry queue and an eight-bit delay field. It drives one oversample strobe every four clocks, so a bit lasts 64 clocks and a full queue plus one overflow frame fits in a short run. Random frame formats sweep every width from one to eight bits with both parity senses and both stop counts, and inject parity and stop faults. Directed cases cover glitches, breaks, overflow, a pop when empty, and a three-bit-time ready delay measured in clocks.

// File: rtl/uart_rx_dlyrdy_pkg.sv
package uart_rx_dlyrdy_pkg;

    // oversample strobes per bit cell and the strobe index sampled
    localparam int OS_RATE   = 16;
    localparam int SAMPLE_PT = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic fe;
        logic pe;
        logic brk;
    } rx_err_t;

    // acc: xor of data bits, pbit: received parity bit
    function automatic logic parity_fault(input logic acc, input logic pbit,
                                          input logic even);
        return (acc ^ pbit) ^ ~even;
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_dlyrdy_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              os_tick,
    input  logic [SEL_W-1:0]  width_sel,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              two_stop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output rx_err_t           out_err
);
    localparam int OS_W = $clog2(OS_RATE);

    logic [1:0]        sync_q;
    logic              rxd_s;
    logic              prev_q;
    logic [OS_W-1:0]   os_cnt;
    rx_state_e         state;
    logic [SEL_W-1:0]  idx;
    logic [DATA_W-1:0] data_q;
    logic              acc_q, pbit_q, perr_q;
    logic              stop2_q, stop0_q;

    logic sample, s0_now, last_stop;

    assign rxd_s     = sync_q[1];
    assign sample    = os_tick && (os_cnt == OS_W'(SAMPLE_PT));
    assign s0_now    = stop2_q ? stop0_q : rxd_s;
    assign last_stop = !two_stop || stop2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 2'b11;
            prev_q    <= 1'b0;
            os_cnt    <= '0;
            state     <= ST_IDLE;
            idx       <= '0;
            data_q    <= '0;
            acc_q     <= 1'b0;
            pbit_q    <= 1'b0;
            perr_q    <= 1'b0;
            stop2_q   <= 1'b0;
            stop0_q   <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= '0;
        end else begin
            sync_q    <= {sync_q[0], rxd};
            out_valid <= 1'b0;
            out_err   <= '0;
            if (os_tick) begin
                prev_q <= rxd_s;
                os_cnt <= os_cnt + 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (os_tick && prev_q && !rxd_s) begin
                        state  <= ST_START;
                        os_cnt <= OS_W'(1);
                    end
                end
                ST_START: begin
                    if (sample) begin
                        if (rxd_s) begin
                            state <= ST_IDLE;
                        end else begin
                            state  <= ST_DATA;
                            idx    <= '0;
                            data_q <= '0;
                            acc_q  <= 1'b0;
                        end
                    end
                end
                ST_DATA: begin
                    if (sample) begin
                        data_q[idx] <= rxd_s;
                        acc_q       <= acc_q ^ rxd_s;
                        if (idx == width_sel) begin
                            state   <= par_en ? ST_PAR : ST_STOP;
                            stop2_q <= 1'b0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (sample) begin
                        pbit_q  <= rxd_s;
                        perr_q  <= parity_fault(acc_q, rxd_s, par_even);
                        state   <= ST_STOP;
                        stop2_q <= 1'b0;
                    end
                end
                ST_STOP: begin
                    if (sample) begin
                        if (!last_stop) begin
                            stop0_q <= rxd_s;
                            stop2_q <= 1'b1;
                        end else begin
                            out_valid   <= 1'b1;
                            out_data    <= data_q;
                            out_err.fe  <= !rxd_s || !s0_now;
                            out_err.pe  <= par_en && perr_q;
                            out_err.brk <= (data_q == '0) && !(par_en && pbit_q) && !s0_now;
                            state       <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              overrun
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic full, do_pop, do_push;

    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count   <= count + CNT_W'(do_push) - CNT_W'(do_pop);
            overrun <= push && full && !do_pop;
        end
    end

endmodule

// File: rtl/uart_rx_rdy_delay.sv
module uart_rx_rdy_delay
    import uart_rx_dlyrdy_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             os_tick,
    input  logic [CNT_W-1:0] count,
    input  logic [DLY_W-1:0] dly,
    output logic             ready
);
    localparam int SUB_W = $clog2(OS_RATE);

    logic [SUB_W-1:0] sub_q;
    logic [DLY_W-1:0] bits_q;
    logic             rdy_q;
    logic             nonempty;

    assign nonempty = (count != '0);
    assign ready    = rdy_q && nonempty;

    always_ff @(posedge clk) begin
        if (rst || !nonempty) begin
            sub_q  <= '0;
            bits_q <= '0;
            rdy_q  <= 1'b0;
        end else begin
            if (os_tick && !rdy_q) begin
                sub_q <= sub_q + 1'b1;
                if (sub_q == SUB_W'(OS_RATE - 1) && bits_q != '1)
                    bits_q <= bits_q + 1'b1;
            end
            if (dly == '0 || bits_q >= dly)
                rdy_q <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_dlyrdy.sv
module uart_rx_dlyrdy
    import uart_rx_dlyrdy_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int DLY_W  = 8,
    parameter int SEL_W  = $clog2(DATA_W),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              os_tick,
    input  logic [SEL_W-1:0]  cfg_width_sel,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_two_stop,
    input  logic [DLY_W-1:0]  cfg_rdy_dly,
    input  logic              rd_pop,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_count,
    output logic              brk_pulse,
    output logic              fe_pulse,
    output logic              pe_pulse,
    output logic              ovr_pulse,
    output logic              rx_ready
);
    logic              frm_valid;
    logic [DATA_W-1:0] frm_data;
    rx_err_t           frm_err;

    uart_rx_frame #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .rxd       (rxd),
        .os_tick   (os_tick),
        .width_sel (cfg_width_sel),
        .par_en    (cfg_par_en),
        .par_even  (cfg_par_even),
        .two_stop  (cfg_two_stop),
        .out_valid (frm_valid),
        .out_data  (frm_data),
        .out_err   (frm_err)
    );

    uart_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (frm_valid),
        .push_data (frm_data),
        .pop       (rd_pop),
        .head      (rd_data),
        .count     (rd_count),
        .overrun   (ovr_pulse)
    );

    uart_rx_rdy_delay #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_rdy (
        .clk     (clk),
        .rst     (rst),
        .os_tick (os_tick),
        .count   (rd_count),
        .dly     (cfg_rdy_dly),
        .ready   (rx_ready)
    );

    assign wr_valid  = frm_valid;
    assign wr_data   = frm_data;
    assign brk_pulse = frm_err.brk;
    assign fe_pulse  = frm_err.fe;
    assign pe_pulse  = frm_err.pe;

endmodule

// File: rtl/uart_rx_dlyrdy_chk.sv
module uart_rx_dlyrdy_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             push,
    input logic             pop,
    input logic [CNT_W-1:0] count,
    input logic             ovr,
    input logic             ready,
    input logic [DLY_W-1:0] dly,
    input logic             brk,
    input logic             fe
);
    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_push_grows_r6: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && count < CNT_W'(DEPTH)) |=> (count == $past(count) + 1'b1));

    p_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (pop && count == '0 && !push) |=> (count == '0));

    p_overrun_full_r7: assert property (@(posedge clk) disable iff (rst)
        ovr |-> ($past(count) == CNT_W'(DEPTH) && $past(push)));

    p_ready_held_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && !pop) |=> ready);

    p_zero_delay_r9: assert property (@(posedge clk) disable iff (rst)
        (dly == '0 && count != '0 && !pop) |=> ready);

    p_break_fe_r4: assert property (@(posedge clk) disable iff (rst)
        brk |-> fe);

endmodule

bind uart_rx_dlyrdy uart_rx_dlyrdy_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .push  (frm_valid),
    .pop   (rd_pop),
    .count (rd_count),
    .ovr   (ovr_pulse),
    .ready (rx_ready),
    .dly   (cfg_rdy_dly),
    .brk   (brk_pulse),
    .fe    (fe_pulse)
);

// File: tb/uart_rx_dlyrdy_bench.sv
`timescale 1ns/1ps
module uart_rx_dlyrdy_bench;
    localparam int TDIV    = 4;
    localparam int BIT_CLK = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic [2:0] cfg_width_sel = 3'd7;
    logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_two_stop = 1'b0;
    logic [7:0] cfg_rdy_dly = 8'd0;
    logic       rd_pop = 1'b0;
    logic       wr_valid;
    logic [7:0] wr_data, rd_data;
    logic [4:0] rd_count;
    logic       brk_pulse, fe_pulse, pe_pulse, ovr_pulse, rx_ready;

    int checks = 0;
    int errors = 0;
    int cap_n = 0, ovr_n = 0;
    logic [7:0] cap_data;
    logic cap_fe, cap_pe, cap_brk;

    always #2.5 clk = ~clk;

    uart_rx_dlyrdy u_uart_rx_dlyrdy (
        .clk(clk), .rst(rst), .rxd(rxd), .os_tick(os_tick),
        .cfg_width_sel(cfg_width_sel), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
        .cfg_rdy_dly(cfg_rdy_dly), .rd_pop(rd_pop),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_data(rd_data),
        .rd_count(rd_count), .brk_pulse(brk_pulse), .fe_pulse(fe_pulse),
        .pe_pulse(pe_pulse), .ovr_pulse(ovr_pulse), .rx_ready(rx_ready)
    );

    // oversample strobe: one clock in every TDIV
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % TDIV;
            os_tick = (tc == 0);
        end
    end

    // capture of completed frames
    always @(negedge clk) begin
        if (wr_valid) begin
            cap_n    <= cap_n + 1;
            cap_data <= wr_data;
            cap_fe   <= fe_pulse;
            cap_pe   <= pe_pulse;
            cap_brk  <= brk_pulse;
        end
        if (ovr_pulse) ovr_n <= ovr_n + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wmask(input int w);
        return 8'((1 << w) - 1);
    endfunction

    function automatic logic good_parity(input logic [7:0] d, input int w, input logic even);
        logic x = ^(d & wmask(w));
        return even ? x : ~x;
    endfunction

    task automatic drive_bit(input logic b);
        @(negedge clk);
        rxd = b;
        repeat (BIT_CLK - 1) @(negedge clk);
    endtask

    // sends one frame; returns the parity bit actually sent
    task automatic send_frame(input logic [7:0] d, input int w, input bit pen, input bit peven,
                              input bit two, input bit badpar, input bit s0low, input bit s1low,
                              output logic pb);
        @(negedge clk);
        cfg_width_sel = 3'(w - 1);
        cfg_par_en    = pen;
        cfg_par_even  = peven;
        cfg_two_stop  = two;
        pb = good_parity(d, w, peven) ^ badpar;
        drive_bit(1'b0);
        for (int i = 0; i < w; i++) drive_bit(d[i]);
        if (pen) drive_bit(pb);
        drive_bit(!s0low);
        if (two) drive_bit(!s1low);
        drive_bit(1'b1);
    endtask

    task automatic run_frame(input logic [7:0] d, input int w, input bit pen, input bit peven,
                             input bit two, input bit badpar, input bit s0low, input bit s1low);
        int n0 = cap_n;
        logic pb;
        logic exp_brk;
        send_frame(d, w, pen, peven, two, badpar, s0low, s1low, pb);
        exp_brk = ((d & wmask(w)) == 8'h00) && (!pen || !pb) && s0low;
        chk("R6 one write per frame", 32'(cap_n), 32'(n0 + 1));
        chk("R1 data width and alignment", 32'(cap_data), 32'(d & wmask(w)));
        chk("R2 parity flag", 32'(cap_pe), 32'(pen && badpar));
        chk("R3 stop flag", 32'(cap_fe), 32'(s0low || (two && s1low)));
        chk("R4 break flag", 32'(cap_brk), 32'(exp_brk));
    endtask

    task automatic pop_one;
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed = $urandom(32'h5eed);
        logic pb;
        int n0, t;
        logic [7:0] sent [16];

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 count after reset", 32'(rd_count), 0);
        chk("R10 ready after reset", 32'(rx_ready), 0);
        chk("R10 pulses after reset", 32'({wr_valid, brk_pulse, fe_pulse, pe_pulse, ovr_pulse}), 0);
        repeat (2 * BIT_CLK) @(negedge clk);

        // random formats, zero delay, one character at a time (R1 R2 R3 R9)
        for (int k = 0; k < 30; k++) begin
            int w = $urandom_range(1, 8);
            logic [7:0] d = 8'($urandom) & wmask(w);
            bit pen = 1'($urandom);
            bit pev = 1'($urandom);
            bit two = 1'($urandom);
            bit bp  = pen && ($urandom % 4 == 0);
            bit s0  = ($urandom % 6 == 0);
            bit s1  = two && ($urandom % 6 == 0);
            cfg_rdy_dly = 8'd0;
            run_frame(d, w, pen, pev, two, bp, s0, s1);
            chk("R9 ready with zero delay", 32'(rx_ready), 1);
            chk("R6 head data", 32'(rd_data), 32'(d));
            chk("R6 count one", 32'(rd_count), 1);
            pop_one();
            chk("R8 ready drops when empty", 32'(rx_ready), 0);
            chk("R6 count after pop", 32'(rd_count), 0);
        end

        // directed break and plain bad stop (R4 R3)
        run_frame(8'h00, 8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        pop_one();
        run_frame(8'h55, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        pop_one();
        run_frame(8'hA3, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        pop_one();

        // glitch on the line (R5)
        n0 = cap_n;
        @(negedge clk);
        rxd = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        chk("R5 glitch writes nothing", 32'(cap_n), 32'(n0));
        chk("R5 glitch count", 32'(rd_count), 0);

        // fill past capacity (R6 R7)
        n0 = ovr_n;
        for (int k = 0; k < 17; k++) begin
            logic [7:0] d = 8'(k * 13 + 1);
            if (k < 16) sent[k] = d;
            send_frame(d, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, pb);
        end
        chk("R7 count stays full", 32'(rd_count), 16);
        chk("R7 one overrun pulse", 32'(ovr_n), 32'(n0 + 1));
        for (int k = 0; k < 16; k++) begin
            chk("R6 queue order", 32'(rd_data), 32'(sent[k]));
            pop_one();
        end
        chk("R6 drained", 32'(rd_count), 0);
        pop_one();
        chk("R6 pop on empty ignored", 32'(rd_count), 0);

        // programmed delay of three bit times (R8)
        cfg_rdy_dly = 8'd3;
        t = 0;
        fork
            send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, pb);
            begin
                while (rd_count == 0) @(negedge clk);
                while (!rx_ready && t < 1000) begin
                    @(negedge clk);
                    t++;
                end
            end
        join
        checks++;
        if (t < 3 * BIT_CLK - 6 || t > 3 * BIT_CLK + 6) begin
            errors++;
            $display("FAIL R8 ready delay actual=%0d expected=%0d", t, 3 * BIT_CLK);
        end
        chk("R8 ready held", 32'(rx_ready), 1);
        pop_one();
        chk("R8 ready cleared on empty", 32'(rx_ready), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule